// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects interrupt conditions from a graphics engine and presents them to the host on one interrupt line. Two kinds of source are supported. Event sources deliver a single-cycle pulse, and the block latches each pulse into a sticky pending bit. Level sources report a condition that lasts over time, such as the binner running out of memory. The pending bit of a level source tracks its condition. An acknowledge therefore removes the bit for only one cycle while the condition is still present.

The host reaches the block over a simple 32-bit register bus. Writes take effect at the clock edge, and reads are combinational from the registered state. The enable mask can only be changed through two dedicated registers. One register sets mask bits and the other clears them, and a write of 0 to any bit leaves that bit unchanged. Either register reads back the same mask. The block also holds an overflow pool base and an overflow pool size. The host writes these to give the binner new memory, and both values are driven out to the binner.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: While reset is active and after it is released, the pending bits, the enable mask, the pool base and the pool size all read as zero, and irq_out is low.
- R2: A write to the status register (word index 0) clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value. Event sources occupy bits 0 and up (frame-done is bit 0), and level sources follow them (out-of-memory is bit 1).
- R3: An event pending bit is set on the clock edge that follows a pulse. It stays set until a write-1 clears it, and after that it stays clear until the next pulse.
- R4: If an event pulse and a write-1 clear of the same bit arrive in the same cycle, the bit is set after the edge.
- R5: After each clock edge, a level pending bit equals its condition as sampled at that edge. A write-1 in the same cycle forces it to 0 for that one edge, and it is set again on the following edge if the condition still holds.
- R6: A write to the enable-set register (word index 1) sets each mask bit whose write-data bit is 1, and leaves the other mask bits unchanged.
- R7: A write to the enable-clear register (word index 2) clears each mask bit whose write-data bit is 1, and leaves the other mask bits unchanged. The mask changes only through these two registers.
- R8: Reads of word index 1 and of word index 2 both return the current enable mask. Word indexes 5 to 7 read as zero, and writes to them change nothing.
- R9: Writes to word index 3 (pool base) and to word index 4 (pool size) store all 32 bits. The stored values read back through the bus and drive pool_base and pool_size from the following cycle.
- R10: irq_out is the OR over all bits of (pending AND mask), taken from the registered state with no extra delay. A pending bit whose enable is off still reads as set.
- R11: A single write with data 0b11 clears both pending bits, enables both sources, or disables both sources, depending on the register written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W (3) | Word index of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the addressed register, combinational |
| evt_pulse | input | EVT_SRCS (1) | Single-cycle event pulses (frame done) |
| lvl_cond | input | LVL_SRCS (1) | Level conditions (binner out of memory) |
| pool_base | output | DATA_W (32) | Overflow pool base address |
| pool_size | output | DATA_W (32) | Overflow pool size |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
The bench builds the block with its default parameters. This gives one event source at bit 0, one level source at bit 1, a 3-bit word index and 32-bit data. With a 3-bit index the random traffic reaches every slot, including the three unused ones, so reads and ignored writes to them are covered. With only two pending bits, random traffic hits every pairing of pulse, level condition, acknowledge and mask within a few thousand cycles. This includes a set arriving together with a clear of the same bit, and an acknowledge issued while the level condition is held.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
    // Word indexes on the register bus
    localparam int unsigned IDX_STATUS  = 0;
    localparam int unsigned IDX_EN_SET  = 1;
    localparam int unsigned IDX_EN_CLR  = 2;
    localparam int unsigned IDX_POOL_BA = 3;
    localparam int unsigned IDX_POOL_SZ = 4;
endpackage

// File: rtl/gfx_irq_status.sv
module gfx_irq_status #(
    parameter int unsigned EVT_SRCS = 1,
    parameter int unsigned LVL_SRCS = 1,
    localparam int unsigned NSRC = EVT_SRCS + LVL_SRCS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EVT_SRCS-1:0] evt_i,
    input  logic [LVL_SRCS-1:0] lvl_i,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] pend_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
    } state_t;

    state_t st_d, st_q;
    logic [NSRC-1:0] pend_nxt;

    // Sticky event bits: a new pulse beats an acknowledge
    for (genvar i = 0; i < EVT_SRCS; i++) begin : g_evt
        assign pend_nxt[i] = evt_i[i] | (st_q.pend[i] & ~ack_i[i]);
    end

    // Level bits track the condition, dropped for one edge on acknowledge
    for (genvar j = 0; j < LVL_SRCS; j++) begin : g_lvl
        assign pend_nxt[EVT_SRCS+j] = lvl_i[j] & ~ack_i[EVT_SRCS+j];
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/gfx_irq_enable.sv
module gfx_irq_enable #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] mask_o
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mask = (st_q.mask | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/gfx_irq_pool.sv
module gfx_irq_pool #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic              size_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] size_o
);
    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] size;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (base_we) st_d.base = wdata;
        if (size_we) st_d.size = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o = st_q.base;
    assign size_o = st_q.size;
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
    import gfx_irq_pkg::*;
#(
    parameter int unsigned EVT_SRCS = 1,
    parameter int unsigned LVL_SRCS = 1,
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned NSRC    = EVT_SRCS + LVL_SRCS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [EVT_SRCS-1:0] evt_pulse,
    input  logic [LVL_SRCS-1:0] lvl_cond,
    output logic [DATA_W-1:0]   pool_base,
    output logic [DATA_W-1:0]   pool_size,
    output logic                irq_out
);
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] en_q;
    logic            hit_status, hit_set, hit_clr, hit_base, hit_size;
    logic [NSRC-1:0] ack_bits, set_bits, clr_bits;

    // Write decode
    always_comb begin
        hit_status = bus_we && (bus_addr == ADDR_W'(IDX_STATUS));
        hit_set    = bus_we && (bus_addr == ADDR_W'(IDX_EN_SET));
        hit_clr    = bus_we && (bus_addr == ADDR_W'(IDX_EN_CLR));
        hit_base   = bus_we && (bus_addr == ADDR_W'(IDX_POOL_BA));
        hit_size   = bus_we && (bus_addr == ADDR_W'(IDX_POOL_SZ));
        ack_bits   = hit_status ? bus_wdata[NSRC-1:0] : '0;
        set_bits   = hit_set    ? bus_wdata[NSRC-1:0] : '0;
        clr_bits   = hit_clr    ? bus_wdata[NSRC-1:0] : '0;
    end

    gfx_irq_status #(
        .EVT_SRCS (EVT_SRCS),
        .LVL_SRCS (LVL_SRCS)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_pulse),
        .lvl_i  (lvl_cond),
        .ack_i  (ack_bits),
        .pend_o (status_q)
    );

    gfx_irq_enable #(
        .NSRC (NSRC)
    ) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_bits),
        .clr_i  (clr_bits),
        .mask_o (en_q)
    );

    gfx_irq_pool #(
        .DATA_W (DATA_W)
    ) u_pool (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_we (hit_base),
        .size_we (hit_size),
        .wdata   (bus_wdata),
        .base_o  (pool_base),
        .size_o  (pool_size)
    );

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(IDX_STATUS):  bus_rdata = DATA_W'(status_q);
            ADDR_W'(IDX_EN_SET),
            ADDR_W'(IDX_EN_CLR):  bus_rdata = DATA_W'(en_q);
            ADDR_W'(IDX_POOL_BA): bus_rdata = pool_base;
            ADDR_W'(IDX_POOL_SZ): bus_rdata = pool_size;
            default:              bus_rdata = '0;
        endcase
    end

    assign irq_out = |(status_q & en_q);
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk
    import gfx_irq_pkg::*;
#(
    parameter int unsigned EVT_SRCS = 1,
    parameter int unsigned LVL_SRCS = 1,
    parameter int unsigned ADDR_W   = 3,
    localparam int unsigned NSRC    = EVT_SRCS + LVL_SRCS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NSRC-1:0]     wr_bits,
    input logic [EVT_SRCS-1:0] evt_pulse,
    input logic [LVL_SRCS-1:0] lvl_cond,
    input logic [NSRC-1:0]     status_q,
    input logic [NSRC-1:0]     en_q,
    input logic                irq_out
);
    logic w_st, w_set, w_clr;
    assign w_st  = bus_we && (bus_addr == ADDR_W'(IDX_STATUS));
    assign w_set = bus_we && (bus_addr == ADDR_W'(IDX_EN_SET));
    assign w_clr = bus_we && (bus_addr == ADDR_W'(IDX_EN_CLR));

    for (genvar i = 0; i < EVT_SRCS; i++) begin : g_evt_chk
        AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[i] |=> status_q[i]); // R4
        AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !(w_st && wr_bits[i])) |=> status_q[i]); // R3
        AST_EVT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (!status_q[i] && !evt_pulse[i]) |=> !status_q[i]); // R3
    end

    for (genvar j = 0; j < LVL_SRCS; j++) begin : g_lvl_chk
        AST_LVL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            !lvl_cond[j] |=> !status_q[EVT_SRCS+j]); // R5
        AST_LVL_REASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_cond[j] && !(w_st && wr_bits[EVT_SRCS+j])) |=> status_q[EVT_SRCS+j]); // R5
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_en_chk
        AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (w_set && wr_bits[k]) |=> en_q[k]); // R6
        AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (w_clr && wr_bits[k]) |=> !en_q[k]); // R7
    end

    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_set || w_clr) |=> $stable(en_q)); // R7

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((|status_q) && (|en_q))); // R10
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(
    .EVT_SRCS (EVT_SRCS),
    .LVL_SRCS (LVL_SRCS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_bits   (bus_wdata[EVT_SRCS+LVL_SRCS-1:0]),
    .evt_pulse (evt_pulse),
    .lvl_cond  (lvl_cond),
    .status_q  (status_q),
    .en_q      (en_q),
    .irq_out   (irq_out)
);

// File: tb/gfx_irq_ctrl_test.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [0:0]  evt_pulse = '0;
    logic [0:0]  lvl_cond = '0;
    logic [31:0] pool_base, pool_size;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the register state
    logic [1:0]  m_st = '0;
    logic [1:0]  m_en = '0;
    logic [31:0] m_ba = '0;
    logic [31:0] m_sz = '0;

    always #2 clk = ~clk;

    gfx_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .lvl_cond(lvl_cond), .pool_base(pool_base), .pool_size(pool_size),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:       return {30'd0, m_st};
            3'd1, 3'd2: return {30'd0, m_en};
            3'd3:       return m_ba;
            3'd4:       return m_sz;
            default:    return 32'd0;
        endcase
    endfunction

    function automatic logic [1:0] nxt_status(input logic [1:0] st, input logic we,
            input logic [2:0] a, input logic [31:0] wd, input logic ev, input logic lc);
        logic [1:0] ack;
        ack = (we && a == 3'd0) ? wd[1:0] : 2'b00;
        return {lc & ~ack[1], ev | (st[0] & ~ack[0])};
    endfunction

    function automatic logic [1:0] nxt_enable(input logic [1:0] en, input logic we,
            input logic [2:0] a, input logic [31:0] wd);
        logic [1:0] s, c;
        s = (we && a == 3'd1) ? wd[1:0] : 2'b00;
        c = (we && a == 3'd2) ? wd[1:0] : 2'b00;
        return (en | s) & ~c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle, entered and left at a falling edge
    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                        input logic ev, input logic lc, input string tag);
        bus_we = we; bus_addr = a; bus_wdata = wd; evt_pulse = ev; lvl_cond = lc;
        #1;
        if (!we) check({tag, " read"}, bus_rdata, exp_read(a));
        @(posedge clk);
        m_st = nxt_status(m_st, we, a, wd, ev, lc);
        m_en = nxt_enable(m_en, we, a, wd);
        if (we && a == 3'd3) m_ba = wd;
        if (we && a == 3'd4) m_sz = wd;
        @(negedge clk);
        check({tag, " irq"}, {31'd0, irq_out}, {31'd0, |(m_st & m_en)});
        check({tag, " pool_base"}, pool_base, m_ba);
        check({tag, " pool_size"}, pool_size, m_sz);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C0FFEE));
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'd0, irq_out}, 32'd0);
        bus_addr = 3'd0; #1 check("R1 status in reset", bus_rdata, 32'd0);
        bus_addr = 3'd1; #1 check("R1 mask in reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b0, 3'd3, 32'd0, 1'b0, 1'b0, "R1 base");
        step(1'b0, 3'd4, 32'd0, 1'b0, 1'b0, "R1 size");

        // R3 R10: latched event is pending but masked
        step(1'b0, 3'd0, 32'd0, 1'b1, 1'b0, "R3 pulse");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R10 masked pending");
        // R6 R8: enable bit 0, read via both mask registers
        step(1'b1, 3'd1, 32'h1, 1'b0, 1'b0, "R6 set");
        step(1'b0, 3'd1, 32'd0, 1'b0, 1'b0, "R8 set-read");
        step(1'b0, 3'd2, 32'd0, 1'b0, 1'b0, "R8 clr-read");
        // R2: zero bit leaves pending bit 0 alone
        step(1'b1, 3'd0, 32'h2, 1'b0, 1'b0, "R2 zero bit");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R2 kept");
        // R4: pulse and clear together
        step(1'b1, 3'd0, 32'h1, 1'b1, 1'b0, "R4 set wins");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R4 still pending");
        // R3: clear then stays clear
        step(1'b1, 3'd0, 32'h1, 1'b0, 1'b0, "R3 clear");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R3 stays clear");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R3 stays clear 2");
        // R5: level bit with acknowledge while held
        step(1'b1, 3'd1, 32'h2, 1'b0, 1'b1, "R5 enable+raise");
        step(1'b1, 3'd0, 32'h2, 1'b0, 1'b1, "R5 ack");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b1, "R5 dropped one edge");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b1, "R5 reasserted");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R5 follows");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R5 low");
        // R7: disable bit 1 only
        step(1'b1, 3'd2, 32'h2, 1'b0, 1'b0, "R7 clr");
        step(1'b0, 3'd2, 32'd0, 1'b0, 1'b0, "R7 mask");
        // R11: both bits in one write
        step(1'b0, 3'd0, 32'd0, 1'b1, 1'b1, "R11 raise both");
        step(1'b1, 3'd1, 32'h3, 1'b0, 1'b0, "R11 enable both");
        step(1'b0, 3'd1, 32'd0, 1'b0, 1'b0, "R11 mask both");
        step(1'b1, 3'd0, 32'h3, 1'b0, 1'b0, "R11 clear both");
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, "R11 cleared");
        step(1'b1, 3'd2, 32'h3, 1'b0, 1'b0, "R11 disable both");
        step(1'b0, 3'd2, 32'd0, 1'b0, 1'b0, "R11 disabled");
        // R9: pool registers
        step(1'b1, 3'd3, 32'hDEAD_B000, 1'b0, 1'b0, "R9 base");
        step(1'b1, 3'd4, 32'h0004_0000, 1'b0, 1'b0, "R9 size");
        step(1'b0, 3'd3, 32'd0, 1'b0, 1'b0, "R9 base read");
        step(1'b0, 3'd4, 32'd0, 1'b0, 1'b0, "R9 size read");
        // R8: unused slots ignore writes and read zero
        step(1'b1, 3'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 unused write");
        step(1'b1, 3'd7, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 unused write 7");
        step(1'b0, 3'd6, 32'd0, 1'b0, 1'b0, "R8 unused read");
        step(1'b0, 3'd1, 32'd0, 1'b0, 1'b0, "R8 mask unchanged");

        // Random traffic covering R2 to R11
        begin
            logic lc;
            lc = 1'b0;
            for (int n = 0; n < 4000; n++) begin
                logic we;
                logic [2:0] a;
                logic [31:0] wd;
                logic ev;
                we = ($urandom % 2) == 0;
                a  = 3'($urandom % 8);
                wd = $urandom;
                ev = ($urandom % 4) == 0;
                if (($urandom % 8) == 0) lc = ~lc;
                step(we, a, wd, ev, lc, "R2-R11 random");
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule